// File: doc/BRIEF.md
# Four-Tap Coefficient Multiply-Accumulate Datapath

This block is a pipelined four-tap multiply-accumulate engine for image filtering and pixel interpolation. Each clock it can take a new set of four 12-bit two's complement samples. Each sample has its own active-low load enable. The block also takes an 8-bit row index with its own active-low load enable. The row index picks one 12-bit coefficient from each of four 256-entry coefficient banks. After a fetch stage, the samples and coefficients feed four signed multipliers. A two-level adder tree reduces the four products, and the result enters a 32-bit accumulator.

An accumulate control travels with each input set. When it is low, the set starts a new total. When it is high, the set's product sum is added to the running total. The full 32-bit accumulator value is presented at the output together with a valid flag, for a downstream shift, round and limit stage.

A separate loader fills the coefficient banks through a simple write port: one row of four coefficients per write.

Top module: `quad_mac`

## Requirements
- R1: For one input set, the output equals the signed sum d0*c0 + d1*c1 + d2*c2 + d3*c3, with all operands read as 12-bit two's complement.
- R2: A sample register for tap i (`din[12i+11:12i]`) loads on a rising clock edge only when `din_ld_n[i]` is 0. When the enable is 1, the tap keeps its earlier sample, whatever value is on `din`.
- R3: The row register loads only when `row_ld_n` is 0; otherwise it keeps the previously loaded row. Row value k selects coefficient entry k in all four banks.
- R4: A write with `cw_en` high stores `cw_data[12i+11:12i]` as the tap-i coefficient of row `cw_row`.
- R5: An input set with `accum` = 0 discards the previous total, so the output is that set's product sum alone.
- R6: An input set with `accum` = 1 adds its product sum to the running total. The total is a 32-bit signed value that wraps modulo 2^32 on overflow.
- R7: The accumulator changes only when a valid set reaches it. Cycles with `vld_i` low leave `acc_o` unchanged.
- R8: An input set sampled at edge N (with `vld_i` high) appears on `acc_o`, with `vld_o` high, after edge N+4. A new set can be accepted on every edge, and every valid set produces exactly one result.
- R9: While `rst_n` is low, `acc_o` is 0 and `vld_o` is 0, and all pipeline state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | Four 12-bit signed samples, tap i at bits 12i+11:12i |
| din_ld_n | input | 4 | Active-low load enable per tap sample register |
| row | input | 8 | Coefficient row index |
| row_ld_n | input | 1 | Active-low load enable for the row register |
| accum | input | 1 | 1 adds to the running total, 0 restarts it |
| vld_i | input | 1 | Marks the current input set as valid |
| cw_en | input | 1 | Coefficient row write strobe |
| cw_row | input | 8 | Row written by the loader |
| cw_data | input | 48 | Four 12-bit coefficients, tap i at bits 12i+11:12i |
| acc_o | output | 32 | Accumulator value |
| vld_o | output | 1 | acc_o holds a fresh result |

## Verification
The bench isolates each bank with one-hot sample patterns. A swapped bank or a misplaced coefficient field would then show up as the wrong single coefficient.

It exercises partial sample enables and a held row index. A design that ignored an enable would mix new samples or a new row into the sum.

Restart and continue sets are alternated back to back. A total that failed to clear, or that added one cycle late, gives sums that differ from the expected ones.

A run of 129 most-negative products drives the total across 2^31. A sum that saturated or lost its sign extension would not land on 0x81000000.

Idle cycles and the exact output cycle are checked as well, so any drift in latency or any update on an idle cycle is caught.

// File: rtl/quad_mac.sv
module quad_mac #(
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int AW   = 8,
  parameter int ACCW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*DW-1:0]   din,
  input  logic [3:0]        din_ld_n,
  input  logic [AW-1:0]     row,
  input  logic              row_ld_n,
  input  logic              accum,
  input  logic              vld_i,
  input  logic              cw_en,
  input  logic [AW-1:0]     cw_row,
  input  logic [4*CW-1:0]   cw_data,
  output logic [ACCW-1:0]   acc_o,
  output logic              vld_o
);
  localparam int NT    = 4;
  localparam int PW    = DW + CW;
  localparam int DEPTH = 1 << AW;

  logic [NT*CW-1:0]         bank [DEPTH];
  logic [NT-1:0][DW-1:0]    d_r, dm;
  logic [NT-1:0][CW-1:0]    cm;
  logic [AW-1:0]            row_r;
  logic signed [PW-1:0]     prod [NT];
  logic signed [ACCW-1:0]   s01, s23;
  logic [3:0]               v_p, a_p;

  always_ff @(posedge clk)
    if (cw_en) bank[cw_row] <= cw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_r   <= '0;
      dm    <= '0;
      cm    <= '0;
      row_r <= '0;
      v_p   <= '0;
      a_p   <= '0;
      s01   <= '0;
      s23   <= '0;
      acc_o <= '0;
      vld_o <= 1'b0;
      for (int i = 0; i < NT; i++) prod[i] <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (!din_ld_n[i]) d_r[i] <= din[i*DW +: DW];
        prod[i] <= PW'($signed(dm[i])) * PW'($signed(cm[i]));
      end
      if (!row_ld_n) row_r <= row;
      dm  <= d_r;
      cm  <= bank[row_r];
      v_p <= {v_p[2:0], vld_i};
      a_p <= {a_p[2:0], accum};
      s01 <= ACCW'(prod[0]) + ACCW'(prod[1]);
      s23 <= ACCW'(prod[2]) + ACCW'(prod[3]);
      if (v_p[3]) acc_o <= (a_p[3] ? acc_o : '0) + s01 + s23;
      vld_o <= v_p[3];
    end
  end

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    age >= 3'd5 |-> vld_o == $past(vld_i, 5));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v_p[3] |=> $stable(acc_o));

  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    age == 3'd0 |-> (acc_o == '0 && !vld_o));

  // R2 and R3: held samples, held row and no write keep the multiplier operands
  a_r3_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && $past(&din_ld_n, 2) && $past(row_ld_n, 2) && !$past(cw_en, 2))
      |-> ($stable(dm) && $stable(cm)));
endmodule

// File: tb/quad_mac_bench.sv
module quad_mac_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] din = '0;
  logic [3:0]  din_ld_n = 4'hF;
  logic [7:0]  row = '0;
  logic        row_ld_n = 1'b1;
  logic        accum = 1'b0;
  logic        vld_i = 1'b0;
  logic        cw_en = 1'b0;
  logic [7:0]  cw_row = '0;
  logic [47:0] cw_data = '0;
  logic [31:0] acc_o;
  logic        vld_o;

  always #(CLK_P/2) clk = ~clk;

  quad_mac u_quad_mac (
    .clk(clk), .rst_n(rst_n), .din(din), .din_ld_n(din_ld_n),
    .row(row), .row_ld_n(row_ld_n), .accum(accum), .vld_i(vld_i),
    .cw_en(cw_en), .cw_row(cw_row), .cw_data(cw_data),
    .acc_o(acc_o), .vld_o(vld_o)
  );

  // {samples tap3..tap0, row, accum}
  localparam logic [56:0] VEC [8] = '{
    {48'h000_000_000_001, 8'd5, 1'b0},
    {48'h000_000_001_000, 8'd5, 1'b0},
    {48'h000_001_000_000, 8'd5, 1'b0},
    {48'h001_000_000_000, 8'd5, 1'b0},
    {48'hFFF_002_7FF_800, 8'd9, 1'b0},
    {48'hFFF_002_7FF_800, 8'd9, 1'b1},
    {48'h7FF_7FF_7FF_7FF, 8'd5, 1'b1},
    {48'h800_800_800_800, 8'd9, 1'b0}
  };

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [47:0] cmod [256];
  logic [47:0] md;
  logic [7:0]  mrow;
  logic [31:0] macc, e, hold;
  int          c, s;
  string       t, cur_tag = "R9";
  logic [31:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tg, act, ex);
    end
  endtask

  function automatic int tapsum(input logic [47:0] d, input logic [47:0] cf);
    int r = 0;
    for (int i = 0; i < 4; i++)
      r += int'($signed(d[i*12 +: 12])) * int'($signed(cf[i*12 +: 12]));
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      md = '0; mrow = '0; macc = '0;
    end else begin
      if (vld_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected result", acc_o, 32'h0);
        else begin
          e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
          chk(acc_o == e, t, acc_o, e);
          chk(cyc == c + 4, "R8 latency", cyc, c + 4);
        end
      end
      for (int i = 0; i < 4; i++) if (!din_ld_n[i]) md[i*12 +: 12] = din[i*12 +: 12];
      if (!row_ld_n) mrow = row;
      if (vld_i) begin
        s = tapsum(md, cmod[mrow]);
        macc = (accum ? macc : 32'h0) + s;
        exp_q.push_back(macc); cyc_q.push_back(cyc + 1); tag_q.push_back(cur_tag);
      end
    end
  end

  task automatic issue(input logic [47:0] d, input logic [3:0] dn, input logic [7:0] r,
                       input logic rn, input logic a, input logic v, input string tg);
    @(posedge clk); #2;
    din = d; din_ld_n = dn; row = r; row_ld_n = rn; accum = a; vld_i = v; cur_tag = tg;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) issue(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b0, "idle");
  endtask

  task automatic wr(input logic [7:0] r, input logic [47:0] d);
    @(posedge clk); #2;
    cw_en = 1'b1; cw_row = r; cw_data = d; cmod[r] = d;
    @(posedge clk); #2;
    cw_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=end", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc_o == 32'h0, "R9 reset acc", acc_o, 32'h0);
    chk(vld_o == 1'b0, "R9 reset valid", {31'h0, vld_o}, 32'h0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R4: tap i coefficient sits at cw_data[12i+11:12i]
    wr(8'd5, 48'h800_064_FFB_003);
    wr(8'd9, 48'h011_ED4_FFF_7FF);
    wr(8'd7, 48'h800_800_800_800);

    for (int k = 0; k < 8; k++)
      issue(VEC[k][56:9], 4'h0, VEC[k][8:1], 1'b0, VEC[k][0], 1'b1,
            k < 4 ? "R4 bank select" : (k == 4 ? "R1 four-tap sum" :
            (VEC[k][0] ? "R6 accumulate" : "R5 restart")));
    idle(6);

    // R7: idle cycles leave the total alone
    @(negedge clk); hold = acc_o;
    idle(4);
    @(negedge clk);
    chk(acc_o == hold, "R7 idle hold", acc_o, hold);

    // R2 partial sample enables, R3 row hold then load
    issue(48'h005_004_003_002, 4'h0, 8'd5, 1'b0, 1'b0, 1'b1, "R2 load all");
    issue(48'h100_7FF_100_7FF, 4'b1010, 8'd5, 1'b0, 1'b0, 1'b1, "R2 hold taps 1 and 3");
    issue(48'h00A_00B_00C_00D, 4'h0, 8'd9, 1'b1, 1'b0, 1'b1, "R3 row held");
    issue(48'h00A_00B_00C_00D, 4'h0, 8'd9, 1'b0, 1'b0, 1'b1, "R3 row loaded");
    idle(6);

    // R6: 129 products of 2^24 wrap past 2^31
    issue(48'h800_800_800_800, 4'h0, 8'd7, 1'b0, 1'b0, 1'b1, "R6 wrap run");
    for (int k = 0; k < 128; k++)
      issue(48'h800_800_800_800, 4'h0, 8'd7, 1'b0, 1'b1, 1'b1, "R6 wrap run");
    idle(6);
    @(negedge clk);
    chk(acc_o == 32'h8100_0000, "R6 wrap final", acc_o, 32'h8100_0000);
    chk(exp_q.size() == 0, "R8 one result per set", exp_q.size(), 32'h0);

    @(posedge clk); #2 rst_n = 1'b0;
    @(negedge clk);
    chk(acc_o == 32'h0, "R9 mid-run reset acc", acc_o, 32'h0);
    chk(vld_o == 1'b0, "R9 mid-run reset valid", {31'h0, vld_o}, 32'h0);
    @(posedge clk); #2 rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    finish_run();
  end
endmodule